// File: doc/BRIEF.md
# PHY Link-Change Interrupt Controller

This block is the interrupt corner of an Ethernet PHY management register space. It watches a link-status input and records every transition of it as a pending link-change event. Software programs a per-source enable, a global interrupt enable, the pin polarity and a pin drive enable. It learns of events through a status register that carries a sticky summary flag and the current link level.

Registers are reached through a plain synchronous port. Read data is combinational from the current address. Any side effect of a read (clearing a flag) takes place at the clock edge on which the read strobe is high. The interrupt pin is a level output plus a separate drive-enable, so the pad can be released to high impedance. Clearing the summary flag by a read does not release the pin while an enabled source is still pending. Software must also read the source register to drop the pin.

Top module: `phy_link_irq_ctrl`

## Requirements
- R1: After reset every register reads zero except the live link bit; `irq_drive` is 0 and `irq_out` sits at its inactive level (1, since polarity resets to 0).
- R2: Any transition of `link_up`, rising or falling, sets the link-change pending bit (bit 13 of the source register at 0x12) on the next clock, whatever the enables are.
- R3: A read of 0x12 clears the pending bit, unless a new transition is taken on that same edge, in which case the bit stays set.
- R4: Bit 5 of 0x12 is the source enable, readable and writable. Writing 0x12 with zero disables the source: later events still set the pending bit but neither assert the pin nor set the summary flag. Bit 13 cannot be written.
- R5: Bit 7 of the status register at 0x10 is a sticky summary flag. It is set by an event taken while the source enable is 1 and cleared by a read of 0x10, unless such an event is taken on the same edge.
- R6: Writes to 0x10 have no effect; writing zero does not clear the summary flag.
- R7: Bit 0 of 0x10 shows the link level sampled on the previous clock.
- R8: In the configuration register at 0x11, bit 3 (polarity), bit 1 (global enable) and bit 0 (drive enable) are writable and read back; all other bits read zero.
- R9: The interrupt is active when the global enable is 1 and either the summary flag is set or the pending and source-enable bits are both set. After the summary flag is cleared by a read, the interrupt stays active until the pending bit is also cleared.
- R10: The active level of `irq_out` is high when polarity is 1 and low when polarity is 0; the inactive level is the opposite.
- R11: `irq_drive` equals the drive-enable bit of 0x11.
- R12: Addresses other than 0x10, 0x11 and 0x12 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; clears read-sensitive flags on the edge |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| link_up | input | 1 | Current link status |
| irq_out | output | 1 | Interrupt pin level, polarity applied |
| irq_drive | output | 1 | Pin drive enable; 0 releases the pin |

## Verification
Two functions can fall on the same edge: a read that clears a flag and a new link transition that sets it. The bench provokes this by toggling `link_up` and raising the read strobe in the same cycle, once for the source register and once for the status register. It judges the result by reading the register again and expecting the flag to be set. It also checks that the pin stays active after the status read until the source register is read.

// File: rtl/phy_link_irq_ctrl.sv
module phy_link_irq_ctrl #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              link_up,
  output logic              irq_out,
  output logic              irq_drive
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(5'h11);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(5'h12);
  localparam int B_SUM = 7, B_LNK = 0;
  localparam int B_POL = 3, B_GEN = 1, B_OE = 0;
  localparam int B_PEND = 13, B_EN = 5;

  logic link_q, pend, src_en, sum, pol, gen_en, oe;

  wire hit_stat = reg_addr == A_STAT;
  wire hit_cfg  = reg_addr == A_CFG;
  wire hit_src  = reg_addr == A_SRC;
  wire evt      = link_up != link_q;
  wire active   = gen_en && (sum || (pend && src_en));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      pend   <= 1'b0;
      src_en <= 1'b0;
      sum    <= 1'b0;
      pol    <= 1'b0;
      gen_en <= 1'b0;
      oe     <= 1'b0;
    end else begin
      link_q <= link_up;
      if (evt)                      pend <= 1'b1;
      else if (reg_rd && hit_src)   pend <= 1'b0;
      if (evt && src_en)            sum  <= 1'b1;
      else if (reg_rd && hit_stat)  sum  <= 1'b0;
      if (reg_wr && hit_src) src_en <= reg_wdata[B_EN];
      if (reg_wr && hit_cfg) begin
        pol    <= reg_wdata[B_POL];
        gen_en <= reg_wdata[B_GEN];
        oe     <= reg_wdata[B_OE];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_stat) begin
      reg_rdata[B_SUM] = sum;
      reg_rdata[B_LNK] = link_q;
    end else if (hit_cfg) begin
      reg_rdata[B_POL] = pol;
      reg_rdata[B_GEN] = gen_en;
      reg_rdata[B_OE]  = oe;
    end else if (hit_src) begin
      reg_rdata[B_PEND] = pend;
      reg_rdata[B_EN]   = src_en;
    end
  end

  assign irq_out   = pol ? active : !active;
  assign irq_drive = oe;

  p_pend_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up != link_q) |=> pend);
  p_pend_rdclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && hit_src && link_up == link_q) |=> !pend);
  p_en_wr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit_src && reg_wdata == '0) |=> !src_en);
  p_sum_rdclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && hit_stat && !(evt && src_en)) |=> !sum);
  p_sum_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit_stat && !reg_rd && !(evt && src_en)) |=> sum == $past(sum));
  p_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit_cfg) |=> irq_drive == $past(reg_wdata[B_OE]));
endmodule

// File: tb/phy_link_irq_ctrl_tb.sv
module phy_link_irq_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, link_up = 1'b0;
  logic [15:0] reg_rdata;
  logic irq_out, irq_drive;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  phy_link_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .link_up(link_up), .irq_out(irq_out), .irq_drive(irq_drive));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic toggle_link();
    link_up = ~link_up;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd_collide(input logic [4:0] a, output logic [15:0] d);
    link_up = ~link_up;
    rd(a, d);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 drive", {15'd0, irq_drive}, 16'd0);
    chk("R1 pin", {15'd0, irq_out}, 16'd1);
    rd(5'h10, v); chk("R1 stat", v, 16'h0000);
    rd(5'h11, v); chk("R1 cfg", v, 16'h0000);
    rd(5'h12, v); chk("R1 src", v, 16'h0000);
  endtask

  task automatic t_cfg();
    logic [15:0] v;
    wr(5'h11, 16'hFFFF);
    rd(5'h11, v); chk("R8 cfg readback", v, 16'h000B);
    chk("R11 drive on", {15'd0, irq_drive}, 16'd1);
    chk("R10 idle high-pol", {15'd0, irq_out}, 16'd0);
    wr(5'h11, 16'h0000);
    chk("R11 drive off", {15'd0, irq_drive}, 16'd0);
  endtask

  task automatic t_pend();
    logic [15:0] v;
    toggle_link();
    rd(5'h12, v); chk("R2 rise pend", v, 16'h2000);
    rd(5'h12, v); chk("R3 read clears", v, 16'h0000);
    rd(5'h10, v); chk("R7 link bit", v, 16'h0001);
    toggle_link();
    rd(5'h12, v); chk("R2 fall pend", v, 16'h2000);
    rd(5'h10, v); chk("R7 link low", v, 16'h0000);
  endtask

  task automatic t_enable();
    logic [15:0] v;
    wr(5'h12, 16'hFFFF);
    rd(5'h12, v); chk("R4 enable only", v, 16'h0020);
    wr(5'h11, 16'h000B);
    toggle_link();
    chk("R9 pin active", {15'd0, irq_out}, 16'd1);
    wr(5'h10, 16'h0000);
    rd(5'h10, v); chk("R6 write ignored", v, 16'h0081);
    rd(5'h10, v); chk("R5 read clears sum", v, 16'h0001);
    chk("R9 pin held by pend", {15'd0, irq_out}, 16'd1);
    rd(5'h12, v); chk("R9 src value", v, 16'h2020);
    chk("R9 pin released", {15'd0, irq_out}, 16'd0);
  endtask

  task automatic t_polarity();
    logic [15:0] v;
    wr(5'h11, 16'h0003);
    chk("R10 idle low-pol", {15'd0, irq_out}, 16'd1);
    toggle_link();
    chk("R10 active low", {15'd0, irq_out}, 16'd0);
    rd(5'h10, v);
    rd(5'h12, v);
    chk("R10 idle again", {15'd0, irq_out}, 16'd1);
    wr(5'h11, 16'h000B);
  endtask

  task automatic t_disable();
    logic [15:0] v;
    wr(5'h12, 16'h0000);
    rd(5'h12, v); chk("R4 write zero", v, 16'h0000);
    toggle_link();
    chk("R4 pin quiet", {15'd0, irq_out}, 16'd0);
    rd(5'h10, v); chk("R5 no sum when off", v, 16'h0001);
    rd(5'h12, v); chk("R4 pend recorded", v, 16'h2000);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    wr(5'h12, 16'h0020);
    rd_collide(5'h12, v); chk("R3 pre-collide", v, 16'h0020);
    rd(5'h12, v); chk("R3 event wins", v, 16'h2020);
    rd(5'h10, v); chk("R5 sum set", v, 16'h0080);
    rd_collide(5'h10, v); chk("R5 pre-collide", v, 16'h0000);
    rd(5'h10, v); chk("R5 event wins", v, 16'h0081);
    rd(5'h12, v);
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    wr(5'h05, 16'hFFFF);
    rd(5'h05, v); chk("R12 unmapped", v, 16'h0000);
    rd(5'h11, v); chk("R12 cfg intact", v, 16'h000B);
    rd(5'h12, v); chk("R12 src intact", v, 16'h0020);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_pend();
    t_enable();
    t_polarity();
    t_disable();
    t_collide();
    t_unmapped();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule